// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM with four banks, a 13-bit multiplexed address and a 2-bit bank select. A host hands it one request at a time (read, write, refresh or mode load) over a valid/ready port. The block turns each request into a legal command stream: it opens rows, closes rows on a miss, and issues the column command. It also issues auto refresh on its own timer and runs the power-up sequence. Data transfer, byte masking and burst address generation are left to other logic. The column command's cycle on the pins tells that logic when a burst starts.

Every timing minimum is a parameter in picoseconds and is turned into a cycle count by rounding up against the clock period. Each bank keeps its own open row and three down-counters, one each for activate, column and precharge commands. A command goes out only when its counter has reached zero. Auto-precharge is requested through bit 10 of the address on a column command. A precharge with bit 10 high closes every bank.

Back-pressure: `req_ready` is high only in the cycle in which the request's final command is chosen, and it may depend on `req_valid`. The host must hold the request fields stable from the cycle it raises `req_valid` until the cycle with both high. The command for an accepted request appears on the pins in the next cycle. For a mode load, the mode value travels on `req_row`.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Commands are driven on {cs_n, ras_n, cas_n, we_n}. The codes are: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000.
- R2: While reset is held, CKE is low and a no-op is driven. After reset the block issues only no-ops for the first INIT cycles. It then issues, in order, a precharge with A10 = 1, two refreshes and a mode load carrying INIT_MODE on A. No activate, read or write goes out before that mode load.
- R3: Activate puts the row on A[12:0] and the bank on BA[1:0] (00 to 11 select banks 0 to 3). Read and write put the column on A[9:0], the auto-precharge request on A10 and zero on A[12:11]. They go only to an open bank whose open row equals the requested row.
- R4: A request to an open bank holding another row first precharges that bank alone (A10 = 0). A request to the open row issues neither an activate nor a precharge.
- R5: Refresh and mode load go out only when all four banks are closed. Open banks are first closed by a single precharge with A10 = 1.
- R6: Per-bank and cross-bank minimum gaps are kept. Activate to read or write on the same bank is at least tRCD. Precharge to activate is at least tRP. Activate to activate on one bank is at least tRC, and on any two banks at least tRRD. Activate to precharge is at least tRAS.
- R7: Take a read at cycle t with burst length BL. A precharge to that bank comes no earlier than t+BL. With auto-precharge, the next activate to that bank comes no earlier than t+BL+tRP. For a write, write recovery is added: the precharge comes at t+BL-1+tWR or later, and with auto-precharge the next activate at t+BL-1+tWR+tRP or later.
- R8: Two column commands are at least BL cycles apart, so no burst is cut short.
- R9: A pending timer refresh takes priority over host requests. Consecutive refreshes are never more than REFI + 32 cycles apart. A host refresh request is served the same way.
- R10: After a mode load no command follows for tMRD cycles. After a refresh no command follows for tRFC cycles.
- R11: `req_ready` is high only after initialisation and only with `req_valid` high. An accepted read, write or mode load appears on the pins in the following cycle, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 refresh, 3 mode load |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row address, or mode value for a mode load |
| req_col | input | 10 | Column address |
| req_ap | input | 1 | Request auto-precharge after the burst |
| init_done | output | 1 | Power-up sequence finished |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, low true |
| sd_ras_n | output | 1 | Row strobe, low true |
| sd_cas_n | output | 1 | Column strobe, low true |
| sd_we_n | output | 1 | Write enable, low true |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed address |

## Verification
The assertions assume that the host holds `req_op`, `req_bank`, `req_row`, `req_col` and `req_ap` steady while a request waits. They also assume the tMRD and tRFC counts are at least two, so a no-op must follow those commands. The bench driver changes request fields only at falling edges and only after the previous request has been accepted. It never withdraws a pending request. Bench parameters keep every derived count small, so the row hits, row misses, auto-precharge recoveries and refresh interruptions that the stream mixes together all fall inside a short run.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_REFRESH = 2'd2,
    OP_MODE    = 2'd3
  } host_op_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_REF1,
    ST_REF2,
    ST_MODE,
    ST_RUN
  } seq_state_e;

  function automatic int ps_to_cyc(longint ps, longint clk_ps);
    return int'((ps + clk_ps - 1) / clk_ps);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_dly_cnt.sv
module sdram_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;
  logic [W-1:0] dec;

  assign dec  = (cnt == '0) ? '0 : cnt - W'(1);
  assign zero = (cnt == '0);

  // a load never shortens a wait already running
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load && (val > dec)) cnt <= val;
    else                          cnt <= dec;
  end

  // R6: an expired window stays expired until something reloads it
  p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/sdram_bank_ctl.sv
module sdram_bank_ctl #(
  parameter int W           = 4,
  parameter int ROW_W       = 13,
  parameter int LD_ACT_RC   = 0,
  parameter int LD_ACT_RP   = 0,
  parameter int LD_ACT_RDAP = 0,
  parameter int LD_ACT_WRAP = 0,
  parameter int LD_RW_RCD   = 0,
  parameter int LD_PRE_RAS  = 0,
  parameter int LD_PRE_RD   = 0,
  parameter int LD_PRE_WR   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_pre,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             act_ok,
  output logic             rw_ok,
  output logic             pre_ok
);
  logic         act_ld, pre_ld;
  logic [W-1:0] act_val, pre_val;
  logic         col_ap;

  assign col_ap = (do_rd | do_wr) & ap;
  assign act_ld = do_act | do_pre | col_ap;
  assign pre_ld = do_act | do_rd | do_wr;

  always_comb begin
    if (do_act)      act_val = W'(LD_ACT_RC);
    else if (do_pre) act_val = W'(LD_ACT_RP);
    else if (do_rd)  act_val = W'(LD_ACT_RDAP);
    else             act_val = W'(LD_ACT_WRAP);
    if (do_act)      pre_val = W'(LD_PRE_RAS);
    else if (do_rd)  pre_val = W'(LD_PRE_RD);
    else             pre_val = W'(LD_PRE_WR);
  end

  sdram_dly_cnt #(.W(W)) u_act (
    .clk(clk), .rst_n(rst_n), .load(act_ld), .val(act_val), .zero(act_ok));
  sdram_dly_cnt #(.W(W)) u_rw (
    .clk(clk), .rst_n(rst_n), .load(do_act), .val(W'(LD_RW_RCD)), .zero(rw_ok));
  sdram_dly_cnt #(.W(W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(pre_ld), .val(pre_val), .zero(pre_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (do_act) begin
      is_open  <= 1'b1;
      open_row <= row_in;
    end else if (do_pre || col_ap) begin
      is_open  <= 1'b0;
    end
  end

  // R3: column commands reach only an open bank past its tRCD window
  p_rw_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd || do_wr) |-> (is_open && rw_ok));
  // R6: activate only a closed bank whose recovery has run out
  p_act_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!is_open && act_ok));
  // R7: an open bank is closed only after tRAS and write recovery
  p_pre_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pre && is_open) |-> pre_ok);

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic served,
  output logic pending
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tick;
  logic          wrap;

  assign wrap = (tick == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick    <= '0;
      pending <= 1'b0;
    end else begin
      if (!run || served || wrap) tick <= '0;
      else                        tick <= tick + TW'(1);
      if (served)                 pending <= 1'b0;
      else if (run && wrap)       pending <= 1'b1;
    end
  end

  // R9: a raised refresh demand is kept until a refresh goes out
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !served) |=> pending);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter longint CLK_PS    = 7500,
  parameter longint TRCD_PS   = 15000,
  parameter longint TRP_PS    = 15000,
  parameter longint TRRD_PS   = 15000,
  parameter longint TRAS_PS   = 45000,
  parameter longint TRC_PS    = 60000,
  parameter longint TRFC_PS   = 60000,
  parameter longint REFI_PS   = 7800000,
  parameter longint INIT_PS   = 200000000,
  parameter int     TWR_CYC   = 2,
  parameter int     TMRD_CYC  = 2,
  parameter int     BURST_LEN = 4,
  parameter int     BANKS     = 4,
  parameter int     ROW_W     = 13,
  parameter int     COL_W     = 10,
  parameter logic [12:0] INIT_MODE = 13'h032
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_ap,
  output logic                     init_done,
  output logic                     sd_cke,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [$clog2(BANKS)-1:0] sd_ba,
  output logic [ROW_W-1:0]         sd_addr
);
  localparam int BA_W     = $clog2(BANKS);
  localparam int AP_BIT   = 10;
  localparam int T_RCD    = ps_to_cyc(TRCD_PS, CLK_PS);
  localparam int T_RP     = ps_to_cyc(TRP_PS, CLK_PS);
  localparam int T_RRD    = ps_to_cyc(TRRD_PS, CLK_PS);
  localparam int T_RAS    = ps_to_cyc(TRAS_PS, CLK_PS);
  localparam int T_RC     = ps_to_cyc(TRC_PS, CLK_PS);
  localparam int T_RFC    = ps_to_cyc(TRFC_PS, CLK_PS);
  localparam int T_REFI   = ps_to_cyc(REFI_PS, CLK_PS);
  localparam int T_INIT   = imax(1, ps_to_cyc(INIT_PS, CLK_PS));
  localparam int IW       = $clog2(T_INIT + 1);
  // counter loads: a gap of N cycles is a load of N-1
  localparam int LD_RC    = imax(T_RC - 1, 0);
  localparam int LD_RP    = imax(T_RP - 1, 0);
  localparam int LD_RCD   = imax(T_RCD - 1, 0);
  localparam int LD_RAS   = imax(T_RAS - 1, 0);
  localparam int LD_RRD   = imax(T_RRD - 1, 0);
  localparam int LD_RFC   = imax(T_RFC - 1, 0);
  localparam int LD_MRD   = imax(TMRD_CYC - 1, 0);
  localparam int LD_BL    = imax(BURST_LEN - 1, 0);
  localparam int LD_PRD   = LD_BL;
  localparam int LD_PWR   = imax(BURST_LEN - 2 + TWR_CYC, 0);
  localparam int LD_RDAP  = BURST_LEN + T_RP - 1;
  localparam int LD_WRAP  = BURST_LEN - 2 + TWR_CYC + T_RP;
  localparam int LD_MAX   = imax(imax(imax(LD_RC, LD_RDAP), imax(LD_WRAP, LD_RAS)),
                                 imax(imax(LD_RFC, LD_MRD), imax(LD_PWR, LD_RCD)));
  localparam int CW       = $clog2(LD_MAX + 2);

  seq_state_e           st, st_n;
  sd_cmd_e              c_cmd;
  logic [BA_W-1:0]      c_ba;
  logic [ROW_W-1:0]     c_addr;
  logic                 ref_served, ref_pend, want_ref;
  logic [IW-1:0]        init_cnt;
  logic                 init_zero;
  logic                 gen_zero, rrd_zero, col_zero;
  logic [BANKS-1:0]     is_open, act_ok, rw_ok, pre_ok;
  logic [BANKS-1:0]     act_s, rd_s, wr_s, pre_s;
  logic [ROW_W-1:0]     open_row [BANKS];
  logic                 any_open, all_act_ok, all_pre_ok;
  logic                 is_col, c_ap;

  assign any_open   = |is_open;
  assign all_act_ok = &act_ok;
  assign all_pre_ok = &(pre_ok | ~is_open);
  assign init_zero  = (init_cnt == '0);
  assign want_ref   = ref_pend || (req_valid && (req_op == OP_REFRESH));
  assign init_done  = (st == ST_RUN);
  assign is_col     = (c_cmd == CMD_RD) || (c_cmd == CMD_WR);
  assign c_ap       = c_addr[AP_BIT];

  // ---------------- command choice ----------------
  always_comb begin
    c_cmd      = CMD_NOP;
    c_ba       = '0;
    c_addr     = '0;
    req_ready  = 1'b0;
    ref_served = 1'b0;
    st_n       = st;
    unique case (st)
      ST_WAIT: if (init_zero) begin
        c_cmd          = CMD_PRE;
        c_addr[AP_BIT] = 1'b1;
        st_n           = ST_REF1;
      end
      ST_REF1, ST_REF2: if (gen_zero && all_act_ok) begin
        c_cmd = CMD_REF;
        st_n  = (st == ST_REF1) ? ST_REF2 : ST_MODE;
      end
      ST_MODE: if (gen_zero && all_act_ok) begin
        c_cmd  = CMD_MRS;
        c_addr = ROW_W'(INIT_MODE);
        st_n   = ST_RUN;
      end
      default: begin
        if (want_ref || (req_valid && (req_op == OP_MODE))) begin
          if (any_open) begin
            if (gen_zero && all_pre_ok) begin
              c_cmd          = CMD_PRE;
              c_addr[AP_BIT] = 1'b1;
            end
          end else if (gen_zero && all_act_ok) begin
            if (want_ref) begin
              c_cmd      = CMD_REF;
              ref_served = 1'b1;
              req_ready  = req_valid && (req_op == OP_REFRESH);
            end else begin
              c_cmd     = CMD_MRS;
              c_addr    = req_row;
              req_ready = 1'b1;
            end
          end
        end else if (req_valid) begin
          c_ba = req_bank;
          if (is_open[req_bank]) begin
            if (open_row[req_bank] == req_row) begin
              if (rw_ok[req_bank] && col_zero && gen_zero) begin
                c_cmd               = (req_op == OP_WRITE) ? CMD_WR : CMD_RD;
                c_addr[COL_W-1:0]   = req_col;
                c_addr[AP_BIT]      = req_ap;
                req_ready           = 1'b1;
              end
            end else if (pre_ok[req_bank] && gen_zero) begin
              c_cmd = CMD_PRE;
            end
          end else if (act_ok[req_bank] && rrd_zero && gen_zero) begin
            c_cmd  = CMD_ACT;
            c_addr = req_row;
          end
        end
      end
    endcase
  end

  // ---------------- per-bank strobes and state ----------------
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign act_s[b] = (c_cmd == CMD_ACT) && (c_ba == BA_W'(b));
    assign rd_s[b]  = (c_cmd == CMD_RD)  && (c_ba == BA_W'(b));
    assign wr_s[b]  = (c_cmd == CMD_WR)  && (c_ba == BA_W'(b));
    assign pre_s[b] = (c_cmd == CMD_PRE) && (c_addr[AP_BIT] || (c_ba == BA_W'(b)));

    sdram_bank_ctl #(
      .W(CW), .ROW_W(ROW_W),
      .LD_ACT_RC(LD_RC), .LD_ACT_RP(LD_RP), .LD_ACT_RDAP(LD_RDAP),
      .LD_ACT_WRAP(LD_WRAP), .LD_RW_RCD(LD_RCD), .LD_PRE_RAS(LD_RAS),
      .LD_PRE_RD(LD_PRD), .LD_PRE_WR(LD_PWR)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(act_s[b]), .do_rd(rd_s[b]), .do_wr(wr_s[b]), .do_pre(pre_s[b]),
      .ap(c_ap), .row_in(c_addr),
      .is_open(is_open[b]), .open_row(open_row[b]),
      .act_ok(act_ok[b]), .rw_ok(rw_ok[b]), .pre_ok(pre_ok[b])
    );
  end

  // ---------------- shared windows ----------------
  sdram_dly_cnt #(.W(CW)) u_gen (
    .clk(clk), .rst_n(rst_n),
    .load((c_cmd == CMD_REF) || (c_cmd == CMD_MRS)),
    .val((c_cmd == CMD_REF) ? CW'(LD_RFC) : CW'(LD_MRD)),
    .zero(gen_zero));
  sdram_dly_cnt #(.W(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(c_cmd == CMD_ACT), .val(CW'(LD_RRD)),
    .zero(rrd_zero));
  sdram_dly_cnt #(.W(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .load(is_col), .val(CW'(LD_BL)), .zero(col_zero));

  sdram_ref_timer #(.INTERVAL(T_REFI)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(st == ST_RUN), .served(ref_served),
    .pending(ref_pend));

  // ---------------- sequencing and pin registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_WAIT;
      init_cnt <= IW'(T_INIT - 1);
      sd_cke   <= 1'b0;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
      sd_ba    <= '0;
      sd_addr  <= '0;
    end else begin
      st     <= st_n;
      sd_cke <= 1'b1;
      if (st == ST_WAIT && !init_zero) init_cnt <= init_cnt - IW'(1);
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= c_cmd;
      sd_ba   <= c_ba;
      sd_addr <= c_addr;
    end
  end

  // R5: refresh and mode load only with every bank closed
  p_ref_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_cmd == CMD_REF) || (c_cmd == CMD_MRS)) |-> !any_open);
  // R11: acceptance only after start-up and only for a valid request
  p_ready_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (init_done && req_valid));

  if (TMRD_CYC >= 2) begin : g_mrd_chk
    // R10: the cycle after a mode load on the pins carries a no-op
    p_mrs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_MRS) |=>
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));
  end
  if (T_RFC >= 2) begin : g_rfc_chk
    // R10: the cycle after a refresh on the pins carries a no-op
    p_ref_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_REF) |=>
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));
  end

endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;

  localparam int E_RCD = 2, E_RP = 2, E_RRD = 2, E_RAS = 5, E_RC = 6;
  localparam int E_RFC = 6, E_MRD = 2, E_WR = 2, BL = 4;
  localparam int E_INIT = 30, E_REFI = 780, SLACK = 32;
  localparam int MODE0 = 'h032;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ap = 1'b0;
  logic        init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;

  always #5 clk = ~clk;

  sdram_cmd_seq #(
    .CLK_PS(10000), .INIT_PS(300000), .REFI_PS(7800000)
  ) u_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_ap(req_ap), .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr));

  typedef struct {int kind; int bank; int row; int col; int ap;} exp_t;
  exp_t q[$];

  int compared = 0, mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;
  int stage = 0;
  int last_ref = 0, ref_count = 0, act_count = 0;
  bit m_open [4];
  int m_row [4];
  int act_at [4], rw_at [4], pre_at [4];
  int rrd_at = 0, col_at = 0, gen_at = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: independent model of bank state and timing windows
  always @(negedge clk) begin
    if (rst_n) begin : mon
      int cmd, b, a;
      exp_t e;
      cmd = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
      b   = int'(sd_ba);
      a   = int'(sd_addr);
      if (cmd != 'b0111) begin
        chk(cyc >= gen_at, "R10 command inside tMRD/tRFC", cyc, gen_at);
        if (stage < 4) begin
          int want;
          want = (stage == 0) ? 'b0010 : (stage == 3) ? 'b0000 : 'b0001;
          chk(cmd == want, "R2 start-up order", cmd, want);
        end
        case (cmd)
          'b0010: begin
            if (stage == 0) begin
              chk(((a >> 10) & 1) == 1, "R2 first precharge A10", (a >> 10) & 1, 1);
              chk(cyc >= E_INIT, "R2 idle time", cyc, E_INIT);
              stage = 1;
            end
            for (int k = 0; k < 4; k++) begin
              if (((a >> 10) & 1) == 1 || k == b) begin
                if (m_open[k]) chk(cyc >= pre_at[k], "R7 precharge window", cyc, pre_at[k]);
                if (((a >> 10) & 1) == 0) chk(m_open[k], "R4 single precharge to open bank", 0, 1);
                m_open[k] = 1'b0;
                act_at[k] = mx(act_at[k], cyc + E_RP);
              end
            end
          end
          'b0011: begin
            chk(!m_open[b], "R3 activate closed bank", int'(m_open[b]), 0);
            chk(cyc >= act_at[b], "R6 activate after tRC/tRP", cyc, act_at[b]);
            chk(cyc >= rrd_at, "R6 activate after tRRD", cyc, rrd_at);
            m_open[b] = 1'b1; m_row[b] = a;
            act_at[b] = cyc + E_RC; rw_at[b] = cyc + E_RCD;
            pre_at[b] = cyc + E_RAS; rrd_at = cyc + E_RRD;
            act_count++;
          end
          'b0101, 'b0100: begin
            int isw, ap;
            isw = (cmd == 'b0100) ? 1 : 0;
            ap  = (a >> 10) & 1;
            chk(m_open[b], "R3 column to open bank", int'(m_open[b]), 1);
            chk(cyc >= rw_at[b], "R6 column after tRCD", cyc, rw_at[b]);
            chk(cyc >= col_at, "R8 burst not cut", cyc, col_at);
            chk((a >> 11) == 0, "R3 A[12:11] zero", a >> 11, 0);
            if (q.size() == 0) chk(1'b0, "R11 unexpected column command", cmd, -1);
            else begin
              e = q.pop_front();
              chk(e.kind == isw, "R11 op order", isw, e.kind);
              chk(e.bank == b, "R3 bank", b, e.bank);
              chk(e.col == (a & 'h3ff), "R3 column", a & 'h3ff, e.col);
              chk(e.ap == ap, "R3 auto-precharge bit", ap, e.ap);
              chk(m_row[b] == e.row, "R4 open row", m_row[b], e.row);
            end
            col_at = cyc + BL;
            pre_at[b] = mx(pre_at[b], isw ? cyc + BL - 1 + E_WR : cyc + BL);
            if (ap == 1) begin
              m_open[b] = 1'b0;
              act_at[b] = mx(act_at[b], isw ? cyc + BL - 1 + E_WR + E_RP : cyc + BL + E_RP);
            end
          end
          'b0001: begin
            for (int k = 0; k < 4; k++) begin
              chk(!m_open[k], "R5 refresh with banks closed", int'(m_open[k]), 0);
              chk(cyc >= act_at[k], "R7 refresh after recovery", cyc, act_at[k]);
            end
            if (stage == 1 || stage == 2) stage++;
            else chk(cyc - last_ref <= E_REFI + SLACK, "R9 refresh interval",
                     cyc - last_ref, E_REFI + SLACK);
            last_ref = cyc; ref_count++;
            gen_at = cyc + E_RFC;
          end
          'b0000: begin
            for (int k = 0; k < 4; k++)
              chk(!m_open[k], "R5 mode load with banks closed", int'(m_open[k]), 0);
            if (stage == 3) begin
              chk(a == MODE0, "R2 start-up mode value", a, MODE0);
              stage = 4;
            end else if (q.size() == 0) chk(1'b0, "R11 unexpected mode load", a, -1);
            else begin
              e = q.pop_front();
              chk(e.kind == 3, "R11 op order", 3, e.kind);
              chk(e.row == a, "R11 mode value", a, e.row);
            end
            gen_at = cyc + E_MRD;
          end
          default: chk(1'b0, "R1 unknown command code", cmd, 'b0111);
        endcase
      end
    end
  end

  task automatic send(input int op, input int bank, input int row, input int col, input int ap);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_bank = 2'(bank);
    req_row = 13'(row); req_col = 10'(col); req_ap = ap[0];
    if (op != 2) begin
      e.kind = op; e.bank = bank; e.row = row; e.col = col; e.ap = ap;
      q.push_back(e);
    end
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n_act, n_ref;
    repeat (3) @(negedge clk);
    chk(sd_cke == 1'b0, "R2 CKE low in reset", int'(sd_cke), 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 no-op in reset",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 'b0111);
    chk(req_ready == 1'b0, "R11 not ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sd_cke == 1'b1, "R2 CKE high after reset", int'(sd_cke), 1);

    // first request is held across start-up
    send(1, 0, 5, 8, 0);
    chk(stage == 4, "R2 request waits for start-up", stage, 4);
    drain();
    n_act = act_count;
    send(0, 0, 5, 12, 0);                 // row hit
    drain();
    chk(act_count == n_act, "R4 row hit without activate", act_count, n_act);
    send(0, 0, 9, 3, 0);                  // row miss
    drain();
    chk(act_count == n_act + 1, "R4 row miss reopens", act_count, n_act + 1);
    send(1, 1, 3, 'h3ff, 1);              // write with auto-precharge
    send(0, 1, 3, 7, 1);                  // read, bank reopened after recovery
    send(0, 2, 100, 1, 0);
    send(3, 0, 'h021, 0, 0);              // mode load with banks open
    drain();
    n_ref = ref_count;
    send(2, 0, 0, 0, 0);                  // host refresh
    drain();
    chk(ref_count == n_ref + 1, "R9 host refresh served", ref_count, n_ref + 1);

    for (int i = 0; i < 300; i++)
      send(i % 2, (i * 3) % 4, (i / 5) % 6, (i * 37) % 1024, (i % 7 == 0) ? 1 : 0);
    drain();
    repeat (2000) @(negedge clk);       // idle: timer refresh only
    chk(q.size() == 0, "R11 all requests issued", q.size(), 0);
    chk(ref_count >= 5, "R9 refresh count", ref_count, 5);
    chk(cyc - last_ref <= E_REFI + SLACK, "R9 refresh while idle", cyc - last_ref, E_REFI + SLACK);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule